// File: doc/BRIEF.md
# Load-Use and Branch Hazard Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline. It finds the dependencies that result forwarding cannot cover and drives the pipeline's hold, bubble and squash controls. It covers three cases:

- A load whose result is needed by the very next instruction.
- A branch resolved in decode whose operand is still being produced by an ALU instruction in execute.
- A branch whose operand is a load result that has not yet returned.

It also squashes the fetched instruction after a jump or a taken branch.

A thin wrapper inside the same module applies these controls. It holds the program counter register and the fetch/decode instruction register. It captures the decode control word into the decode/execute register, or forces that word to zero to create a bubble. The pipeline registers' reset values are zero, and the PC resets to a parameter.

Top module: `hazard_stall_unit`

## Requirements
- R1: When `ex_mem_read` is 1 and `ex_dst` is nonzero and equals `id_rs` or `id_rt`, a stall is raised in that cycle: `pc_we` = 0, `ifid_we` = 0, `bubble_sel` = 1.
- R2: In a stall cycle, the next clock edge leaves `pc_q` and `ifid_instr_q` unchanged.
- R3: In a stall cycle, the next clock edge loads all zeros into `idex_ctrl_q`.
- R4: When `id_branch` is 1, `ex_reg_write` is 1, and `ex_dst` is nonzero and equals `id_rs` or `id_rt`, a stall is raised.
- R5: When `id_branch` is 1, `mem_mem_read` is 1, and `mem_dst` is nonzero and equals `id_rs` or `id_rt`, a stall is raised. As a result, a branch that follows a load of its operand stalls exactly two cycles.
- R6: When `id_jump` is 1 and no stall is raised, `if_flush` = 1 and the next edge loads all zeros into `ifid_instr_q`.
- R7: When `id_branch` and `id_taken` are both 1 and no stall is raised, `if_flush` = 1. A branch that is not taken raises no flush.
- R8: A destination register number of 0 never causes a stall.
- R9: `if_flush` is 0 in every cycle in which a stall is raised.
- R10: Without a stall or flush, the clock edge loads `pc_next` into `pc_q`, `fetch_instr` into `ifid_instr_q`, and `id_ctrl` into `idex_ctrl_q`.
- R11: While `rst_n` is 0, `pc_q` = RESET_PC, and `ifid_instr_q` and `idex_ctrl_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_mem_read | input | 1 | Instruction in execute is a load |
| ex_reg_write | input | 1 | Instruction in execute writes a register |
| ex_dst | input | REG_W | Destination register of the instruction in execute |
| mem_mem_read | input | 1 | Instruction in memory stage is a load |
| mem_dst | input | REG_W | Destination register of the instruction in memory stage |
| id_rs | input | REG_W | First source register of the instruction in decode |
| id_rt | input | REG_W | Second source register of the instruction in decode |
| id_branch | input | 1 | Decoded instruction is a conditional branch |
| id_jump | input | 1 | Decoded instruction is a jump |
| id_taken | input | 1 | Result of the decode-stage branch compare |
| pc_next | input | PC_W | Next program counter value from the fetch mux |
| fetch_instr | input | INSTR_W | Instruction word being fetched |
| id_ctrl | input | CTRL_W | Control word produced by decode |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| bubble_sel | output | 1 | Selects zero control into decode/execute |
| if_flush | output | 1 | Squash the fetched instruction |
| pc_q | output | PC_W | Program counter register |
| ifid_instr_q | output | INSTR_W | Fetch/decode instruction register |
| idex_ctrl_q | output | CTRL_W | Decode/execute control register |

## Verification
On every cycle, the assertions check the following:

- A stall freezes the PC and the instruction register.
- A stall leaves a zero control word behind it.
- A flush leaves a zero instruction.
- Flush and stall never coincide.
- A comparison against register 0 never holds the pipeline.

The bench sweeps every combination of stage flags and of register numbers 0 to 3 against a model of its own. Only a directed sequence can show the two-cycle hold of a branch behind a load, because that needs the load to move from execute into the memory stage between cycles.

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit #(
  parameter int REG_W   = 5,
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32,
  parameter int CTRL_W  = 9,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ex_mem_read,
  input  logic               ex_reg_write,
  input  logic [REG_W-1:0]   ex_dst,
  input  logic               mem_mem_read,
  input  logic [REG_W-1:0]   mem_dst,
  input  logic [REG_W-1:0]   id_rs,
  input  logic [REG_W-1:0]   id_rt,
  input  logic               id_branch,
  input  logic               id_jump,
  input  logic               id_taken,
  input  logic [PC_W-1:0]    pc_next,
  input  logic [INSTR_W-1:0] fetch_instr,
  input  logic [CTRL_W-1:0]  id_ctrl,
  output logic               pc_we,
  output logic               ifid_we,
  output logic               bubble_sel,
  output logic               if_flush,
  output logic [PC_W-1:0]    pc_q,
  output logic [INSTR_W-1:0] ifid_instr_q,
  output logic [CTRL_W-1:0]  idex_ctrl_q
);

  logic ex_hit, mem_hit, load_use, br_on_ex, br_on_mem, stall;

  assign ex_hit    = (ex_dst  != '0) && (ex_dst  == id_rs || ex_dst  == id_rt);
  assign mem_hit   = (mem_dst != '0) && (mem_dst == id_rs || mem_dst == id_rt);
  assign load_use  = ex_mem_read & ex_hit;
  assign br_on_ex  = id_branch & ex_reg_write & ex_hit;
  assign br_on_mem = id_branch & mem_mem_read & mem_hit;
  assign stall     = load_use | br_on_ex | br_on_mem;

  assign pc_we      = ~stall;
  assign ifid_we    = ~stall;
  assign bubble_sel = stall;
  assign if_flush   = ~stall & (id_jump | (id_branch & id_taken));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q         <= RESET_PC;
      ifid_instr_q <= '0;
      idex_ctrl_q  <= '0;
    end else begin
      if (pc_we) pc_q <= pc_next;
      if (if_flush)     ifid_instr_q <= '0;
      else if (ifid_we) ifid_instr_q <= fetch_instr;
      idex_ctrl_q <= bubble_sel ? '0 : id_ctrl;
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> ($stable(pc_q) && $stable(ifid_instr_q))); // R2
  AST_BUBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |=> (idex_ctrl_q == '0)); // R3
  AST_FLUSH_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    if_flush |=> (ifid_instr_q == '0)); // R6
  AST_NO_FLUSH_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(if_flush && !ifid_we)); // R9
  AST_ZERO_DST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0 && mem_dst == '0) |-> pc_we); // R8
  AST_LOAD_USE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mem_read && ex_dst != '0 && ex_dst == id_rs) |-> !pc_we); // R1

endmodule

// File: tb/hazard_stall_unit_tb_top.sv
`timescale 1ns/1ps
module hazard_stall_unit_tb_top;
  localparam int RW = 5, PW = 32, IW = 32, CW = 9;

  logic clk = 0, rst_n = 0;
  logic ex_mem_read = 0, ex_reg_write = 0, mem_mem_read = 0;
  logic [RW-1:0] ex_dst = 0, mem_dst = 0, id_rs = 0, id_rt = 0;
  logic id_branch = 0, id_jump = 0, id_taken = 0;
  logic [PW-1:0] pc_next = 0;
  logic [IW-1:0] fetch_instr = 0;
  logic [CW-1:0] id_ctrl = 0;
  logic pc_we, ifid_we, bubble_sel, if_flush;
  logic [PW-1:0] pc_q;
  logic [IW-1:0] ifid_instr_q;
  logic [CW-1:0] idex_ctrl_q;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  hazard_stall_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ex_mem_read(ex_mem_read), .ex_reg_write(ex_reg_write),
    .ex_dst(ex_dst), .mem_mem_read(mem_mem_read), .mem_dst(mem_dst), .id_rs(id_rs),
    .id_rt(id_rt), .id_branch(id_branch), .id_jump(id_jump), .id_taken(id_taken),
    .pc_next(pc_next), .fetch_instr(fetch_instr), .id_ctrl(id_ctrl), .pc_we(pc_we),
    .ifid_we(ifid_we), .bubble_sel(bubble_sel), .if_flush(if_flush), .pc_q(pc_q),
    .ifid_instr_q(ifid_instr_q), .idex_ctrl_q(idex_ctrl_q));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  logic [PW-1:0] e_pc;
  logic [IW-1:0] e_ifid;
  logic [CW-1:0] e_idex;

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v;
    int stalls;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 pc reset", 64'(pc_q), 64'h0);
    chk("R11 ifid reset", 64'(ifid_instr_q), 64'h0);
    chk("R11 idex reset", 64'(idex_ctrl_q), 64'h0);
    @(negedge clk); rst_n = 1;
    e_pc = 0; e_ifid = 0; e_idex = 0;
    v = 0;
    for (int f = 0; f < 64; f++) begin
      for (int ed = 0; ed < 4; ed++)
      for (int md = 0; md < 4; md++)
      for (int rs = 0; rs < 4; rs++)
      for (int rt = 0; rt < 4; rt++) begin
        logic ehit, mhit, lu, bex, bmem, st, fl;
        string t_st, t_fl;
        @(negedge clk);
        ex_mem_read = f[0]; ex_reg_write = f[1]; mem_mem_read = f[2];
        id_branch = f[3]; id_jump = f[4]; id_taken = f[5];
        ex_dst = RW'(ed); mem_dst = RW'(md); id_rs = RW'(rs); id_rt = RW'(rt);
        pc_next = 32'h1000 + 32'(v) * 4;
        fetch_instr = 32'hA5A50001 + 32'(v) * 2;
        id_ctrl = CW'(v) | 9'h100;
        v++;
        ehit = (ed != 0) && (ed == rs || ed == rt);
        mhit = (md != 0) && (md == rs || md == rt);
        lu = f[0] & ehit;
        bex = f[3] & f[1] & ehit;
        bmem = f[3] & f[2] & mhit;
        st = lu | bex | bmem;
        fl = !st && (f[4] || (f[3] && f[5]));
        t_st = lu ? "R1 load-use stall" : bex ? "R4 branch on ALU stall" :
               bmem ? "R5 branch on load stall" : "R8 no stall";
        t_fl = (st && (f[4] || (f[3] && f[5]))) ? "R9 flush suppressed" :
               f[4] ? "R6 jump flush" : "R7 branch flush";
        #1;
        chk(t_st, 64'({pc_we, ifid_we, bubble_sel}), st ? 64'b001 : 64'b110);
        chk(t_fl, 64'(if_flush), 64'(fl));
        if (!st) e_pc = pc_next;
        if (fl) e_ifid = '0; else if (!st) e_ifid = fetch_instr;
        e_idex = st ? '0 : id_ctrl;
        @(posedge clk); #1;
        chk(st ? "R2 pc hold" : "R10 pc load", 64'(pc_q), 64'(e_pc));
        chk(fl ? "R6 ifid squash" : st ? "R2 ifid hold" : "R10 ifid load",
            64'(ifid_instr_q), 64'(e_ifid));
        chk(st ? "R3 bubble" : "R10 ctrl load", 64'(idex_ctrl_q), 64'(e_idex));
      end
    end

    // R5: branch right behind a load of its operand stalls exactly two cycles
    stalls = 0;
    @(negedge clk);
    ex_mem_read = 1; ex_reg_write = 1; ex_dst = 3; mem_mem_read = 0; mem_dst = 0;
    id_branch = 1; id_jump = 0; id_taken = 1; id_rs = 3; id_rt = 1;
    #1; if (!pc_we) stalls++;
    @(negedge clk);
    ex_mem_read = 0; ex_reg_write = 0; ex_dst = 0; mem_mem_read = 1; mem_dst = 3;
    #1; if (!pc_we) stalls++;
    chk("R9 no flush while held", 64'(if_flush), 64'h0);
    @(negedge clk);
    mem_mem_read = 0; mem_dst = 0;
    #1; if (!pc_we) stalls++;
    chk("R7 taken flush after hold", 64'(if_flush), 64'h1);
    chk("R5 two-cycle load-branch hold", 64'(stalls), 64'd2);

    @(negedge clk);
    id_branch = 0; id_taken = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule